// File: doc/BRIEF.md
# Priority Time-Slot Channel Scheduler

The scheduler decides which of a set of channels is handed to a shared execution engine next. Each channel is tagged high, middle or low priority by a two-bit field, and raises a request line when it needs service. Service opportunities, called slots, are assigned to priority levels in a fixed repeating seven-slot pattern. That pattern gives high priority four slots, middle two and low one. Within a level, requesting channels are served in rounds, so that no channel at a level is served twice while another channel at the same level is still waiting.

The engine signals the end of a service with a one-cycle done pulse. The scheduler then advances its slot pointer and spends a fixed number of transition cycles before it makes its next decision. When a level opens a new round, a short no-operation period precedes the grant. Both overhead periods appear on a busy output. This makes worst-case latency for any channel directly measurable at the ports.

Top module: `tslot_sched`

## Requirements
- R1: The slot pointer starts at slot 0 and walks slots 0..6 cyclically. Slots 0, 2, 4 and 6 belong to high priority, slots 1 and 5 to middle, and slot 3 to low. The pointer advances by one on each accepted done pulse and at no other time.
- R2: Channel c takes its level from `prio_i[2c+1:2c]`: 2'b00 is low, 2'b01 is middle, and both 2'b10 and 2'b11 are high.
- R3: Within a level, the lowest-numbered requesting channel not yet served in the current round is granted. A channel served in the round is skipped until the round ends.
- R4: A round ends when no unserved channel at the level is requesting, and the level's served set then clears. A grant that opens a round (served set empty or just cleared) is preceded by exactly NOP_CYC busy cycles (default 4). Any other grant follows the decision cycle directly.
- R5: When the current slot's level has no requester, the slot goes to the first level, in the order high, middle, low, that has one.
- R6: With no request at all, the block sits idle with grant valid and busy low and the slot pointer unchanged. A done pulse while no grant is valid is ignored.
- R7: A grant stays valid, with its channel number unchanged, until a done pulse arrives, even if the request drops.
- R8: A done pulse during a grant ends it on the next cycle. This is followed by exactly XFER_CYC busy cycles (default 6) and then one decision cycle with busy and grant low.
- R9: Reset clears every served set, returns the pointer to slot 0, and drops grant valid and busy.
- R10: Grant valid and busy are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | NUM_CH | Per-channel service request |
| prio_i | input | 2*NUM_CH | Per-channel priority fields |
| done_i | input | 1 | One-cycle end-of-service pulse from the engine |
| grant_vld_o | output | 1 | A channel is granted |
| grant_ch_o | output | $clog2(NUM_CH) | Granted channel number, meaningful while grant_vld_o is high |
| busy_o | output | 1 | Transition or no-operation overhead in progress |

## Verification
The hardest situation to reach is a round boundary that falls on a slot borrowed from another level. This happens when the served set of one level is partly filled while a different level's slot is being spent on it. It only appears after a long history of grants across all three levels. The stimulus therefore walks one continuous vector sequence without reset, so that pointer position and served sets carry from one request pattern into the next. Idle periods, a done pulse while idle, and a change of priority encoding then expose stale pointer movement and misdecoded levels.

// File: rtl/tslot_pkg.sv
package tslot_pkg;
  typedef enum logic [1:0] {LVL_LO = 2'd0, LVL_MD = 2'd1, LVL_HI = 2'd2} lvl_e;
  typedef enum logic [1:0] {ST_SEL, ST_NOP, ST_GNT, ST_XFR} st_e;

  localparam int NUM_SLOT = 7;
  localparam int PTR_W    = 3;
  localparam int NUM_LVL  = 3;

  // slot-to-level pattern: H M H L H M H
  function automatic lvl_e slot_lvl(input logic [PTR_W-1:0] ptr);
    lvl_e l;
    case (ptr)
      3'd1, 3'd5: l = LVL_MD;
      3'd3:       l = LVL_LO;
      default:    l = LVL_HI;
    endcase
    return l;
  endfunction

  function automatic lvl_e prio_dec(input logic [1:0] f);
    lvl_e l;
    case (f)
      2'b00:   l = LVL_LO;
      2'b01:   l = LVL_MD;
      default: l = LVL_HI;
    endcase
    return l;
  endfunction
endpackage

// File: rtl/tslot_ovh_cnt.sv
module tslot_ovh_cnt #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (load_i)            cnt_q <= val_i;
    else if (cnt_q != '0)       cnt_q <= cnt_q - W'(1);
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/tslot_lvl_round.sv
module tslot_lvl_round #(
  parameter int NUM_CH = 8,
  parameter int CH_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] req_i,
  input  logic              take_i,
  output logic              any_o,
  output logic              new_rnd_o,
  output logic [CH_W-1:0]   ch_o
);
  logic [NUM_CH-1:0] srv_q;
  logic [NUM_CH-1:0] unsrv;
  logic [NUM_CH-1:0] cand;
  logic              wrap;

  assign unsrv     = req_i & ~srv_q;
  assign wrap      = (unsrv == '0);
  assign cand      = wrap ? req_i : unsrv;
  assign any_o     = |req_i;
  assign new_rnd_o = wrap || (srv_q == '0);

  // lowest index wins
  always_comb begin
    ch_o = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (cand[i]) ch_o = CH_W'(i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     srv_q <= '0;
    else if (take_i) srv_q <= (wrap ? '0 : srv_q) | (NUM_CH'(1) << ch_o);
  end
endmodule

// File: rtl/tslot_sched.sv
module tslot_sched
  import tslot_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int XFER_CYC = 6,
  parameter int NOP_CYC  = 4,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_CH-1:0]   req_i,
  input  logic [2*NUM_CH-1:0] prio_i,
  input  logic                done_i,
  output logic                grant_vld_o,
  output logic [CH_W-1:0]     grant_ch_o,
  output logic                busy_o
);
  localparam int OVH_MAX = (XFER_CYC > NOP_CYC) ? XFER_CYC : NOP_CYC;
  localparam int CNT_W   = $clog2(OVH_MAX + 1);

  st_e              st_q;
  logic [PTR_W-1:0] ptr_q;
  logic [CH_W-1:0]  ch_q;

  logic [NUM_CH-1:0] lvl_req [NUM_LVL];
  logic [NUM_LVL-1:0] lvl_any, lvl_new, take;
  logic [CH_W-1:0]   lvl_ch [NUM_LVL];

  lvl_e       slot_l, sel_l;
  logic       sel_ok;
  logic       cnt_ld, cnt_zero;
  logic [CNT_W-1:0] cnt_val;

  // split requests by level
  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign lvl_req[l][c] = req_i[c] && (prio_dec(prio_i[2*c +: 2]) == lvl_e'(l));
    end
    assign take[l] = (st_q == ST_SEL) && sel_ok && (sel_l == lvl_e'(l));

    tslot_lvl_round #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_round (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .req_i    (lvl_req[l]),
      .take_i   (take[l]),
      .any_o    (lvl_any[l]),
      .new_rnd_o(lvl_new[l]),
      .ch_o     (lvl_ch[l])
    );
  end

  // slot level first, then H, M, L fallback
  always_comb begin
    slot_l = slot_lvl(ptr_q);
    sel_ok = |lvl_any;
    if (lvl_any[slot_l])      sel_l = slot_l;
    else if (lvl_any[LVL_HI]) sel_l = LVL_HI;
    else if (lvl_any[LVL_MD]) sel_l = LVL_MD;
    else                      sel_l = LVL_LO;
  end

  assign cnt_ld  = ((st_q == ST_SEL) && sel_ok && lvl_new[sel_l]) ||
                   ((st_q == ST_GNT) && done_i);
  assign cnt_val = (st_q == ST_SEL) ? CNT_W'(NOP_CYC - 1) : CNT_W'(XFER_CYC - 1);

  tslot_ovh_cnt #(.W(CNT_W)) u_ovh (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(cnt_ld),
    .val_i (cnt_val),
    .zero_o(cnt_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_SEL;
      ptr_q <= '0;
      ch_q  <= '0;
    end else begin
      case (st_q)
        ST_SEL: if (sel_ok) begin
          ch_q <= lvl_ch[sel_l];
          st_q <= lvl_new[sel_l] ? ST_NOP : ST_GNT;
        end
        ST_NOP: if (cnt_zero) st_q <= ST_GNT;
        ST_GNT: if (done_i) begin
          st_q  <= ST_XFR;
          ptr_q <= (ptr_q == PTR_W'(NUM_SLOT - 1)) ? '0 : ptr_q + PTR_W'(1);
        end
        default: if (cnt_zero) st_q <= ST_SEL;
      endcase
    end
  end

  assign grant_vld_o = (st_q == ST_GNT);
  assign busy_o      = (st_q == ST_NOP) || (st_q == ST_XFR);
  assign grant_ch_o  = ch_q;
endmodule

// File: rtl/tslot_sched_chk.sv
module tslot_sched_chk #(
  parameter int NUM_CH   = 8,
  parameter int XFER_CYC = 6,
  parameter int NOP_CYC  = 4,
  parameter int CH_W     = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_CH-1:0] req_i,
  input logic              done_i,
  input logic              grant_vld_o,
  input logic [CH_W-1:0]   grant_ch_o,
  input logic              busy_o
);
  logic [15:0]       run_q;
  logic [NUM_CH-1:0] req_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
      req_d <= '0;
    end else begin
      run_q <= busy_o ? run_q + 16'd1 : '0;
      req_d <= req_i;
    end
  end

  AST_GNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_vld_o && !done_i |=> grant_vld_o && $stable(grant_ch_o)); // R7

  AST_DONE_XFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_vld_o && done_i |=> busy_o && !grant_vld_o); // R8

  AST_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(grant_vld_o && busy_o)); // R10

  AST_IDLE_STAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !grant_vld_o && !busy_o && (req_i == '0) |=> !grant_vld_o && !busy_o); // R6

  AST_OVH_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (run_q == 16'(NOP_CYC)) || (run_q == 16'(XFER_CYC))); // R4 R8

  AST_GNT_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(grant_vld_o) && !$past(busy_o) |-> req_d[grant_ch_o]); // R3
endmodule

bind tslot_sched tslot_sched_chk #(
  .NUM_CH(NUM_CH), .XFER_CYC(XFER_CYC), .NOP_CYC(NOP_CYC), .CH_W(CH_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .done_i     (done_i),
  .grant_vld_o(grant_vld_o),
  .grant_ch_o (grant_ch_o),
  .busy_o     (busy_o)
);

// File: tb/tslot_sched_tb_top.sv
module tslot_sched_tb_top;
  localparam int NUM_CH = 8;
  localparam int XFER   = 6;
  localparam int NOP    = 4;
  localparam int NV     = 25;

  // {req[7:0], exp_ch[3:0], exp_nop[3:0]}
  localparam logic [15:0] VEC [NV] = '{
    16'h0704, 16'h0714, 16'h0704, 16'h0724, 16'h0704, 16'h0714, 16'h0704, 16'h0704,
    16'h1F40, 16'h1F30, 16'h1F24, 16'h1F04, 16'h1F14, 16'h1F30, 16'h1F04, 16'h1F40,
    16'h6050, 16'h6060, 16'h6054, 16'h6060,
    16'h8214, 16'h8214, 16'h8214, 16'h8214, 16'h8270
  };

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [NUM_CH-1:0] req_i = '0;
  logic [15:0]       prio_i = 16'h0186; // ch0 H, ch1 M, ch2 L, ch3 H, ch4 M, ch5..7 L
  logic              done_i = 1'b0;
  logic              grant_vld_o;
  logic [2:0]        grant_ch_o;
  logic              busy_o;

  int n_chk = 0;
  int n_fail = 0;
  bit fin = 1'b0;
  bit overlap = 1'b0;

  always #5 clk_i = ~clk_i;

  tslot_sched #(.NUM_CH(NUM_CH), .XFER_CYC(XFER), .NOP_CYC(NOP)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .prio_i(prio_i), .done_i(done_i),
    .grant_vld_o(grant_vld_o), .grant_ch_o(grant_ch_o), .busy_o(busy_o)
  );

  always @(negedge clk_i) if (rst_ni && grant_vld_o && busy_o) overlap = 1'b1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_grant(input int ech, input int enop, input string tag);
    int pre = 0;
    int w = 0;
    while (!grant_vld_o && w < 100) begin
      if (busy_o) pre++;
      @(negedge clk_i);
      w++;
    end
    chk(grant_vld_o, {tag, " R1 grant seen"}, int'(grant_vld_o), 1);
    chk(grant_ch_o == 3'(ech), {tag, " R1 R3 R5 channel"}, int'(grant_ch_o), ech);
    chk(pre == enop, {tag, " R4 nop cycles"}, pre, enop);
  endtask

  task automatic finish_srv(input string tag);
    int post = 0;
    done_i = 1'b1;
    @(negedge clk_i);
    done_i = 1'b0;
    while (busy_o && post < 50) begin
      post++;
      @(negedge clk_i);
    end
    chk(post == XFER, {tag, " R8 transition cycles"}, post, XFER);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!fin) begin
      n_fail++;
      $display("FAIL watchdog act=0 exp=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!grant_vld_o && !busy_o, "R9 reset outputs", int'({grant_vld_o, busy_o}), 0);
    rst_ni = 1'b1;

    // table walk, no reset between patterns
    for (int v = 0; v < NV; v++) begin
      req_i = VEC[v][15:8];
      wait_grant(int'(VEC[v][7:4]), int'(VEC[v][3:0]), $sformatf("vec%0d", v));
      finish_srv($sformatf("vec%0d", v));
    end

    // R6: idle holds pointer (slot 4), stray done ignored
    req_i = '0;
    begin
      int bad = 0;
      for (int i = 0; i < 20; i++) begin
        if (i == 7) done_i = 1'b1;
        if (i == 8) done_i = 1'b0;
        if (grant_vld_o || busy_o) bad++;
        @(negedge clk_i);
      end
      chk(bad == 0, "R6 idle outputs", bad, 0);
    end
    req_i = 8'h03;
    wait_grant(0, 4, "R6 pointer held");

    // R7: grant held with request dropped
    req_i = '0;
    repeat (10) @(negedge clk_i);
    chk(grant_vld_o && grant_ch_o == 3'd0, "R7 grant held", int'(grant_ch_o), 0);
    req_i = 8'h03;
    finish_srv("R7");
    wait_grant(1, 4, "R7 next slot");
    finish_srv("R7 next");

    // R9: reset in the middle of a grant
    req_i = 8'h1F;
    wait_grant(3, 0, "R9 pre");
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk(!grant_vld_o && !busy_o, "R9 reset mid-grant", int'({grant_vld_o, busy_o}), 0);
    rst_ni = 1'b1;
    wait_grant(0, 4, "R9 slot0 new round");
    finish_srv("R9 a");
    wait_grant(1, 4, "R9 slot1");
    finish_srv("R9 b");
    wait_grant(3, 0, "R9 slot2");
    finish_srv("R9 c");

    // R2: field 2'b11 decodes as high
    prio_i[5:4] = 2'b11;
    req_i = 8'h24;
    wait_grant(5, 4, "R2 low slot");
    finish_srv("R2 a");
    wait_grant(2, 0, "R2 high slot");
    finish_srv("R2 b");

    chk(!overlap, "R10 grant and busy exclusive", int'(overlap), 0);

    fin = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule